// File: doc/BRIEF.md
# I2C Byte-Level Master Controller

This block is a byte-at-a-time I2C bus master. Software loads an outgoing byte into a data buffer, then writes a control word whose transfer-byte bit launches one byte transfer. The same control word can ask for a START condition before the byte, ask for a STOP condition after it, and pick ACK or NAK for a received byte. SCL and SDA are driven as open-drain pull-downs: an output of 1 pulls the line low, and an output of 0 releases it. SDA is read back from the bus.

Clock stretching is done by software. After every byte and its acknowledge bit, the master keeps SCL low until software sets the transfer-byte bit again. START and STOP are not separate commands. They are requests attached to the next byte. The byte that follows a START is the address byte. If its least significant bit is 1, the master switches to receive mode for the bytes after it.

Five status flags report progress and errors: transmit done, receive done, STOP done, NAK on a transmitted byte, and arbitration lost. Software clears a flag by writing 1 to it. The interrupt line is the OR of the flags whose enable bit is set. Bit timing comes from a prescaler that divides the system clock into quarter-bit ticks.

Top module: `i2cb_master`

## Requirements
- R1: After reset the control word, the flags, the data buffer and the interrupt are 0, and both lines are released. While the bus is idle, both lines stay released.
- R2: Control bit 3 (transfer-byte) is set by a control write and cleared by hardware only when the byte and its acknowledge bit have finished. While it reads 1, writes to the control word and to the data buffer are ignored.
- R3: Control bit 0 asks for a START condition (SDA falling while SCL is high) ahead of the byte. This works from an idle bus and, as a repeated START, from a bus the master is holding.
- R4: A byte takes nine SCL clocks: eight data bits, most significant bit first, then the acknowledge bit. SDA changes only while SCL is low.
- R5: After a byte with no STOP request, SCL stays low until the transfer-byte bit is set again.
- R6: In receive mode the master releases SDA for the eight data bits and loads the sampled byte into the data buffer. In the acknowledge slot it drives low (ACK) when control bit 2 is 0, and releases SDA (NAK) when it is 1.
- R7: Control bit 1 asks for a STOP condition (SDA rising while SCL is high) after the byte's acknowledge bit. Flag bit 2 sets when the STOP completes, and both lines are then released.
- R8: Flag bit 0 sets after a transmitted byte, flag bit 1 after a received byte, and flag bit 3 when a transmitted byte was answered with NAK. These flags set in the same cycle the transfer-byte bit clears, and never earlier. Writing 1 to a bit of flag_clr clears that flag.
- R9: If SDA is sampled low with SCL high while the master leaves SDA released for a 1 data bit, flag bit 4 sets at the byte end. The master stops driving SDA for the rest of that byte and then releases SCL without sending a STOP.
- R10: irq is 1 exactly when some flag is set and its bit in irq_en is 1.
- R11: Each bit lasts four quarter periods of prescale+1 clocks each. SCL is released for two of them, which is 2*(prescale+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale | input | PSW | Quarter-bit divider; one tick every prescale+1 clocks |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word: {transfer-byte, nak, stop, start} |
| ctl_q | output | 4 | Control word readback |
| dat_we | input | 1 | Data buffer write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| dat_q | output | 8 | Data buffer readback (holds the last received byte) |
| flag_clr | input | 5 | Write-one-to-clear mask for the flags |
| irq_en | input | 5 | Interrupt enable per flag |
| flag_q | output | 5 | Flags: {lost, nak, stop done, rx done, tx done} |
| irq | output | 1 | Interrupt request |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong sequencer phase shows on the wire within one quarter period: SDA moves while SCL is high, or a START or STOP appears where a data bit belongs. The bus monitor sees either fault as a mismatched event at the next byte boundary. A wrong bit counter or shift register changes the byte value or the acknowledge level that the monitor records, so the error shows at the end of that byte. Wrong flag or transfer-byte timing is visible at the first cycle after the acknowledge bit, where flags and the transfer-byte bit are compared together. A lost STOP or a stuck hold shows as a missing STOP-done flag, or as SCL still pulled low when it should be released.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int DW   = 8;
  localparam int NFLG = 5;

  localparam int FLG_TE = 0;
  localparam int FLG_RF = 1;
  localparam int FLG_SD = 2;
  localparam int FLG_BE = 3;
  localparam int FLG_AL = 4;

  localparam int CB_START = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_NAK   = 2;
  localparam int CB_TB    = 3;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BIT, ST_HOLD, ST_STOP} eng_st_t;

  // {scl_oe, sda_oe} for each quarter of a START sequence
  function automatic logic [1:0] start_lines(input logic [1:0] q);
    case (q)
      2'd0:    return 2'b10;
      2'd1:    return 2'b00;
      2'd2:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  // {scl_oe, sda_oe} for each quarter of a STOP sequence
  function automatic logic [1:0] stop_lines(input logic [1:0] q);
    case (q)
      2'd0:    return 2'b11;
      2'd1:    return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  // SCL is pulled low in the first and last quarter of a bit
  function automatic logic bit_scl_low(input logic [1:0] q);
    return (q == 2'd0) || (q == 2'd3);
  endfunction

  function automatic logic [NFLG-1:0] byte_flags(input logic rx, input logic nacked,
                                                 input logic lost);
    logic [NFLG-1:0] f;
    f         = '0;
    f[FLG_TE] = !rx;
    f[FLG_RF] = rx;
    f[FLG_BE] = !rx && nacked && !lost;
    f[FLG_AL] = lost;
    return f;
  endfunction
endpackage

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
  parameter int PSW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [PSW-1:0] prescale,
  output logic           tick
);
  logic [PSW-1:0] cnt;

  assign tick = run && (cnt == prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine import i2cb_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            go,
  input  logic            req_start,
  input  logic            req_stop,
  input  logic            nak,
  input  logic [DW-1:0]   txbyte,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  output eng_st_t         st,
  output logic            byte_done,
  output logic            stop_done,
  output logic [NFLG-1:0] done_flags,
  output logic [DW-1:0]   rx_byte,
  output logic            rx_load,
  output logic            al_drop
);
  logic [1:0]    qph;
  logic [3:0]    bitn;
  logic [DW-1:0] shreg;
  logic          samp, al_hit, is_rx, rx_mode, first, addr_rd, stop_q, nak_q;
  logic          data_slot;

  assign data_slot  = !bitn[3];
  assign byte_done  = tick && (st == ST_BIT) && (qph == 2'd3) && !data_slot;
  assign stop_done  = tick && (st == ST_STOP) && (qph == 2'd3);
  assign done_flags = byte_flags(is_rx, samp, al_hit);
  assign rx_byte    = shreg;
  assign rx_load    = byte_done && is_rx;
  assign al_drop    = (st == ST_BIT) && data_slot && al_hit;

  always_comb begin
    unique case (st)
      ST_IDLE:  {scl_oe, sda_oe} = 2'b00;
      ST_HOLD:  {scl_oe, sda_oe} = 2'b10;
      ST_START: {scl_oe, sda_oe} = start_lines(qph);
      ST_STOP:  {scl_oe, sda_oe} = stop_lines(qph);
      ST_BIT: begin
        scl_oe = bit_scl_low(qph);
        sda_oe = data_slot ? (!is_rx && !al_hit && !shreg[DW-1]) : (is_rx && !nak_q);
      end
      default:  {scl_oe, sda_oe} = 2'b00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; qph <= '0; bitn <= '0; shreg <= '0; samp <= 1'b0;
      al_hit <= 1'b0; is_rx <= 1'b0; rx_mode <= 1'b0; first <= 1'b0;
      addr_rd <= 1'b0; stop_q <= 1'b0; nak_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE, ST_HOLD: if (go) begin
          shreg <= txbyte; stop_q <= req_stop; nak_q <= nak;
          qph <= '0; bitn <= '0; al_hit <= 1'b0;
          if (req_start || st == ST_IDLE) begin
            st <= ST_START; first <= 1'b1; is_rx <= 1'b0; addr_rd <= txbyte[0];
          end else begin
            st <= ST_BIT; first <= 1'b0; is_rx <= rx_mode;
          end
        end
        ST_START: if (tick) begin
          qph <= qph + 2'd1;
          if (qph == 2'd3) st <= ST_BIT;
        end
        ST_BIT: if (tick) begin
          qph <= qph + 2'd1;
          if (qph == 2'd2) begin
            samp <= sda_i;
            if (data_slot && !is_rx && !al_hit && shreg[DW-1] && !sda_i) al_hit <= 1'b1;
          end
          if (qph == 2'd3) begin
            if (data_slot) begin
              shreg <= {shreg[DW-2:0], samp};
              bitn  <= bitn + 4'd1;
            end else begin
              if (first) rx_mode <= addr_rd;
              st <= al_hit ? ST_IDLE : (stop_q ? ST_STOP : ST_HOLD);
            end
          end
        end
        ST_STOP: if (tick) begin
          qph <= qph + 2'd1;
          if (qph == 2'd3) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cb_flags.sv
module i2cb_flags import i2cb_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLG-1:0] set,
  input  logic [NFLG-1:0] clr,
  input  logic [NFLG-1:0] en,
  output logic [NFLG-1:0] flags,
  output logic            irq
);
  assign irq = |(flags & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/i2cb_master.sv
module i2cb_master import i2cb_pkg::*; #(
  parameter int PSW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PSW-1:0]  prescale,
  input  logic            ctl_we,
  input  logic [3:0]      ctl_wdata,
  output logic [3:0]      ctl_q,
  input  logic            dat_we,
  input  logic [DW-1:0]   dat_wdata,
  output logic [DW-1:0]   dat_q,
  input  logic [NFLG-1:0] flag_clr,
  input  logic [NFLG-1:0] irq_en,
  output logic [NFLG-1:0] flag_q,
  output logic            irq,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe
);
  eng_st_t         eng_st;
  logic            tick, run, go;
  logic            byte_done, stop_done, rx_load, al_drop;
  logic [NFLG-1:0] done_flags, flag_set;
  logic [DW-1:0]   rx_byte;

  assign run = (eng_st == ST_START) || (eng_st == ST_BIT) || (eng_st == ST_STOP);
  assign go  = ctl_q[CB_TB] && ((eng_st == ST_IDLE) || (eng_st == ST_HOLD));

  always_comb begin
    flag_set         = byte_done ? done_flags : '0;
    flag_set[FLG_SD] = stop_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ctl_q <= '0;
    else if (ctl_we && !ctl_q[CB_TB])   ctl_q <= ctl_wdata;
    else if (byte_done)                 ctl_q[CB_TB] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         dat_q <= '0;
    else if (rx_load)                   dat_q <= rx_byte;
    else if (dat_we && !ctl_q[CB_TB])   dat_q <= dat_wdata;
  end

  i2cb_tick #(.PSW(PSW)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .prescale(prescale), .tick(tick)
  );

  i2cb_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go),
    .req_start(ctl_q[CB_START]), .req_stop(ctl_q[CB_STOP]), .nak(ctl_q[CB_NAK]),
    .txbyte(dat_q), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .st(eng_st),
    .byte_done(byte_done), .stop_done(stop_done), .done_flags(done_flags),
    .rx_byte(rx_byte), .rx_load(rx_load), .al_drop(al_drop)
  );

  i2cb_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .en(irq_en),
    .flags(flag_q), .irq(irq)
  );
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker import i2cb_pkg::*; (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_oe,
  input logic            sda_oe,
  input logic [3:0]      ctl_q,
  input logic [NFLG-1:0] flag_q,
  input eng_st_t         eng_st,
  input logic            byte_done,
  input logic            stop_done,
  input logic            al_drop
);
  AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_st == ST_IDLE) |-> (!scl_oe && !sda_oe)); // R1

  AST_TB_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[CB_TB]) |-> $past(byte_done)); // R2

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng_st == ST_BIT) && ($past(eng_st) == ST_BIT) && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe)); // R4

  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_st == ST_HOLD) |-> scl_oe); // R5

  AST_HOLD_LEAVES_ON_TB: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng_st == ST_HOLD) && ctl_q[CB_TB]) |=> (eng_st != ST_HOLD)); // R5

  AST_SD_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[FLG_SD]) |-> $past(stop_done)); // R7

  AST_TE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[FLG_TE]) |-> $past(byte_done)); // R8

  AST_RF_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[FLG_RF]) |-> $past(byte_done)); // R8

  AST_AL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    al_drop |-> !sda_oe); // R9
endmodule

bind i2cb_master i2cb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .ctl_q(ctl_q),
  .flag_q(flag_q), .eng_st(eng_st), .byte_done(byte_done), .stop_done(stop_done),
  .al_drop(al_drop)
);

// File: tb/test_i2cb_master.sv
module test_i2cb_master;
  import i2cb_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int PSW = 8;
  localparam logic [6:0] SLV_ADDR = 7'h50;

  logic clk, rst_n;
  logic [PSW-1:0] prescale;
  logic ctl_we, dat_we;
  logic [3:0] ctl_wdata, ctl_q;
  logic [7:0] dat_wdata, dat_q;
  logic [NFLG-1:0] flag_clr, irq_en, flag_q;
  logic irq, sda_i, scl_oe, sda_oe;
  logic slv_drv, foreign;
  logic scl_w;

  assign scl_w = !scl_oe;
  assign sda_i = !(sda_oe || slv_drv || foreign);

  i2cb_master #(.PSW(PSW)) i_i2cb_master (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_q(dat_q),
    .flag_clr(flag_clr), .irq_en(irq_en), .flag_q(flag_q), .irq(irq), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int last_high = 0;
  logic [10:0] exp_q[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] ev_start();  return {2'd1, 9'd0}; endfunction
  function automatic logic [10:0] ev_stop();   return {2'd3, 9'd0}; endfunction
  function automatic logic [10:0] ev_byte(input logic a, input logic [7:0] d);
    return {2'd2, a, d};
  endfunction

  // scoreboard compare: the monitor reports each bus event here
  task automatic observe(input logic [10:0] ev);
    logic [10:0] ex;
    if (exp_q.size() == 0) begin
      chk("R4", "unexpected bus event", int'(ev), 0);
    end else begin
      ex = exp_q.pop_front();
      case (ex[10:9])
        2'd1:    chk("R3", "START event", int'(ev), int'(ex));
        2'd3:    chk("R7", "STOP event", int'(ev), int'(ex));
        default: chk(ex[8] ? "R6" : "R4", "byte event {ack,data}", int'(ev), int'(ex));
      endcase
    end
  endtask

  // bus monitor plus addressed target model
  initial begin : monitor
    logic p_scl, p_sda, c_scl, c_sda;
    logic in_addr, sel, rd_mode, slv_ack;
    logic [7:0] sh, rd_byte, rd_val;
    int bitc, hi_cnt;
    p_scl = 1; p_sda = 1; in_addr = 0; sel = 0; rd_mode = 0; slv_ack = 0;
    sh = 0; rd_byte = 0; rd_val = 8'hA5; bitc = 0; hi_cnt = 0;
    slv_drv = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      c_scl = scl_w; c_sda = sda_i;
      if (c_scl) hi_cnt++;
      else if (p_scl) begin last_high = hi_cnt; hi_cnt = 0; end
      if (p_scl && c_scl && p_sda && !c_sda) begin
        observe(ev_start()); bitc = 0; in_addr = 1; rd_mode = 0; slv_drv = 0;
      end else if (p_scl && c_scl && !p_sda && c_sda) begin
        observe(ev_stop()); bitc = 0; in_addr = 0; rd_mode = 0; sel = 0; slv_drv = 0;
      end else if (!p_scl && c_scl) begin
        if (bitc < 8) begin
          sh = {sh[6:0], c_sda}; bitc++;
          if (bitc == 8) begin
            if (in_addr) begin sel = (sh[7:1] == SLV_ADDR); slv_ack = sel; end
            else if (!rd_mode) slv_ack = sel && (sh != 8'hEE);
          end
        end else begin
          observe(ev_byte(c_sda, sh)); bitc = 0;
          if (in_addr) begin
            in_addr = 0; rd_mode = sel && sh[0];
            if (rd_mode) begin rd_byte = rd_val; rd_val++; end
          end else if (rd_mode) begin
            if (c_sda) rd_mode = 0;
            else begin rd_byte = rd_val; rd_val++; end
          end
        end
      end else if (p_scl && !c_scl) begin
        if (bitc == 8)                   slv_drv = (in_addr || !rd_mode) ? slv_ack : 1'b0;
        else if (rd_mode && !in_addr)    slv_drv = !rd_byte[7-bitc];
        else                             slv_drv = 1'b0;
      end
      p_scl = c_scl; p_sda = c_sda;
    end
  end

  task automatic clear_flags();
    @(negedge clk); flag_clr = '1;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic launch(input logic st, input logic sp, input logic nk);
    @(negedge clk); ctl_we = 1; ctl_wdata = {1'b1, nk, sp, st};
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wait_done();
    while (ctl_q[CB_TB]) @(negedge clk);
  endtask

  task automatic wait_sd();
    while (!flag_q[FLG_SD]) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk); dat_we = 1; dat_wdata = d;
    @(negedge clk); dat_we = 0;
  endtask

  // driver: pushes expected bus events, then starts the byte
  task automatic tx_byte(input logic [7:0] d, input logic st, input logic sp,
                         input logic exp_nak);
    clear_flags();
    load(d);
    if (st) exp_q.push_back(ev_start());
    exp_q.push_back(ev_byte(exp_nak, d));
    if (sp) exp_q.push_back(ev_stop());
    launch(st, sp, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8", "no flag before ack bit", int'(flag_q), 0);
    chk("R2", "transfer-byte held while busy", int'(ctl_q[CB_TB]), 1);
    wait_done();
  endtask

  task automatic rx_byte(input logic nk, input logic sp, input logic [7:0] exp_d);
    clear_flags();
    exp_q.push_back(ev_byte(nk, exp_d));
    if (sp) exp_q.push_back(ev_stop());
    launch(1'b0, sp, nk);
    wait_done();
    chk("R6", "received byte in buffer", int'(dat_q), int'(exp_d));
    chk("R8", "rx done flag", int'(flag_q), 1 << FLG_RF);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 0; prescale = 3; ctl_we = 0; ctl_wdata = 0; dat_we = 0; dat_wdata = 0;
    flag_clr = 0; irq_en = 0; foreign = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "control after reset", int'(ctl_q), 0);
    chk("R1", "flags after reset", int'(flag_q), 0);
    chk("R1", "data after reset", int'(dat_q), 0);
    chk("R1", "lines released", int'({scl_oe, sda_oe}), 0);
    chk("R1", "irq after reset", int'(irq), 0);

    // address write, hold afterwards
    irq_en = 5'b1 << FLG_TE;
    tx_byte(8'hA0, 1, 0, 0);
    chk("R8", "tx done flag", int'(flag_q), 1 << FLG_TE);
    chk("R10", "irq with enabled flag", int'(irq), 1);
    chk("R11", "SCL high clocks p=3", last_high, 8);
    repeat (40) @(negedge clk);
    chk("R5", "SCL held low in wait", int'(scl_oe), 1);
    @(negedge clk); flag_clr = 5'b1 << FLG_TE;
    @(negedge clk); flag_clr = 0;
    chk("R8", "write-one-to-clear", int'(flag_q), 0);
    chk("R10", "irq drops after clear", int'(irq), 0);

    // data byte, with ignored writes while busy
    clear_flags();
    load(8'h3C);
    exp_q.push_back(ev_byte(0, 8'h3C));
    launch(0, 0, 0);
    @(negedge clk); ctl_we = 1; ctl_wdata = 4'b0110; dat_we = 1; dat_wdata = 8'h00;
    @(negedge clk); ctl_we = 0; dat_we = 0;
    chk("R2", "control write ignored while busy", int'(ctl_q), 8);
    wait_done();
    chk("R2", "data write ignored while busy", int'(dat_q), 8'h3C);

    // NAKed byte with STOP
    tx_byte(8'hEE, 0, 1, 1);
    chk("R8", "tx done plus nak flags", int'(flag_q), (1 << FLG_TE) | (1 << FLG_BE));
    wait_sd();
    chk("R7", "lines released after STOP", int'({scl_oe, sda_oe}), 0);

    // read: address with R bit, ACK one byte, NAK the last with STOP
    tx_byte(8'hA1, 1, 0, 0);
    rx_byte(0, 0, 8'hA5);
    rx_byte(1, 1, 8'hA6);
    wait_sd();
    chk("R7", "STOP done flag", int'(flag_q[FLG_SD]), 1);

    // unanswered address at fastest rate
    prescale = 0;
    tx_byte(8'h42, 1, 1, 1);
    chk("R11", "SCL high clocks p=0", last_high, 2);
    chk("R8", "address nak flag", int'(flag_q[FLG_BE]), 1);
    wait_sd();

    // repeated START into a read
    prescale = 5;
    tx_byte(8'hA0, 1, 0, 0);
    chk("R11", "SCL high clocks p=5", last_high, 12);
    tx_byte(8'hA1, 1, 0, 0);
    rx_byte(1, 1, 8'hA7);
    wait_sd();

    // arbitration loss: another driver holds SDA low
    prescale = 3;
    tx_byte(8'hA0, 1, 0, 0);
    clear_flags();
    load(8'hFF);
    foreign = 1;
    exp_q.push_back(ev_byte(0, 8'h00));
    launch(0, 0, 0);
    wait_done();
    chk("R9", "lost plus tx done flags", int'(flag_q), (1 << FLG_AL) | (1 << FLG_TE));
    @(negedge clk);
    chk("R9", "lines released after loss", int'({scl_oe, sda_oe}), 0);
    exp_q.push_back(ev_stop());
    foreign = 0;
    repeat (20) @(negedge clk);
    chk("R4", "all expected bus events seen", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule